// File: doc/BRIEF.md
# Register-Mapped Shift/Rotate Unit

This peripheral shifts or rotates one data word a programmed number of single-bit places. A host talks to it through a write strobe, a one-bit address and a write-data bus. A write to address 0 stores the operand. A write to address 1 stores a control word and starts the operation.

The control word carries three fields. One field selects a logical shift or a rotate, one selects the direction, and one holds a repeat count. The unit then applies one single-bit step per clock until the count is used up. While steps remain, a busy flag is high. When the last step lands, a done flag pulses for one cycle. The result sits on its own output bus, apart from the write-data bus.

Every operation starts from the stored operand, so the host can try several control words on the same value without reloading it.

Top module: `shrot_unit`

## Requirements
- R1: A write with address 0 stores the write data as the operand, and the result output stays unchanged until an operation is started.
- R2: Control word fields: bit 5 = 1 selects rotate and 0 selects logical shift; bit 4 = 1 selects left and 0 selects right; bits [3:0] give the step count 0..15. Bits above bit 5 have no effect.
- R3: A logical shift step fills the vacated bit with 0 and discards the bit shifted out.
- R4: A rotate step moves the bit that leaves one end into the other end. A count equal to the width returns the operand, and larger counts wrap.
- R5: After a control write with count N > 0, busy is high for exactly N cycles, and one step is applied per clock.
- R6: done is high for exactly one cycle, in the cycle after the last step. In that cycle busy is low and the result holds the final value.
- R7: A control write with count 0 raises done in the next cycle, with busy staying low and the result equal to the operand.
- R8: Writes to either address while busy is high are ignored. Neither the running operation nor the stored operand changes.
- R9: After reset, result is 0 and busy and done are low.
- R10: Each control write starts from the stored operand, not from the previous result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 1 | 0 = operand, 1 = control word |
| wrData | input | DATA_W | Host write data |
| result | output | DATA_W | Working value; final result when done |
| busy | output | 1 | Steps remain |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its defaults: an 8-bit word and a 4-bit count. With these values a count of 15 exceeds the word width, so rotate wraparound is exercised. A count of 8 gives a full rotation that must return the operand, and a long shift must clear the word entirely. The small width also lets a hand-worked table of expected words cover every mode and direction, plus the count-0 case and writes that arrive mid-operation.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef struct packed {
    logic loadOp;   // capture operand
    logic startOp;  // copy operand to work register, latch mode
    logic stepOp;   // apply one single-bit step
  } shrot_strobes_t;
endpackage

// File: rtl/shrot_ctrl.sv
module shrot_ctrl
  import shrot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output shrot_strobes_t    strobes,
  output logic              busy,
  output logic              done
);
  logic [CNT_W-1:0] remain;
  logic             accept;
  logic [CNT_W-1:0] reqCount;

  assign reqCount = wrData[CNT_W-1:0];
  assign busy     = (remain != '0);
  assign accept   = wrEn && !busy;

  always_comb begin
    strobes.loadOp  = accept && !wrAddr;
    strobes.startOp = accept && wrAddr;
    strobes.stepOp  = busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strobes.startOp) begin
        remain <= reqCount;
        if (reqCount == '0) done <= 1'b1;
      end else if (busy) begin
        remain <= remain - 1'b1;
        if (remain == CNT_W'(1)) done <= 1'b1;
      end
    end
  end

  // R6: done lasts a single cycle unless a fresh zero-count start follows
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done && !(wrEn && wrAddr) |=> !done);
  // R6: leaving busy always coincides with done
  a_r6_done_on_finish: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R5: done never overlaps busy
  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/shrot_datapath.sv
module shrot_datapath
  import shrot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  shrot_strobes_t    strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] result
);
  localparam int DIR_BIT = CNT_W;
  localparam int ROT_BIT = CNT_W + 1;

  logic [DATA_W-1:0] operandQ;
  logic [DATA_W-1:0] workQ;
  logic [DATA_W-1:0] stepVal;
  logic              rotQ;
  logic              leftQ;
  logic              inBit;

  always_comb begin
    if (leftQ) begin
      inBit   = rotQ ? workQ[DATA_W-1] : 1'b0;
      stepVal = {workQ[DATA_W-2:0], inBit};
    end else begin
      inBit   = rotQ ? workQ[0] : 1'b0;
      stepVal = {inBit, workQ[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      operandQ <= '0;
      workQ    <= '0;
      rotQ     <= 1'b0;
      leftQ    <= 1'b0;
    end else begin
      if (strobes.loadOp) operandQ <= wrData;
      if (strobes.startOp) begin
        workQ <= operandQ;
        rotQ  <= wrData[ROT_BIT];
        leftQ <= wrData[DIR_BIT];
      end else if (strobes.stepOp) begin
        workQ <= stepVal;
      end
    end
  end

  assign result = workQ;

  // R8: control never asks for a step and a register write together
  a_r8_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepOp |-> !strobes.loadOp && !strobes.startOp);
  // R3: left shift leaves a zero in the low bit
  a_r3_left_fill: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepOp && !rotQ && leftQ |=> workQ[0] == 1'b0);
  // R3: right shift leaves a zero in the high bit
  a_r3_right_fill: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepOp && !rotQ && !leftQ |=> workQ[DATA_W-1] == 1'b0);
  // R4: rotate keeps the number of set bits
  a_r4_rot_ones: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepOp && rotQ |=> $countones(workQ) == $countones($past(workQ)));
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] result,
  output logic              busy,
  output logic              done
);
  shrot_strobes_t strobes;

  shrot_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobes(strobes), .busy(busy), .done(done)
  );

  shrot_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData), .result(result)
  );

  // R7: zero-count start finishes in the next cycle without busy
  a_r7_zero_count: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrAddr && !busy && (wrData[CNT_W-1:0] == '0) |=> done && !busy);
  // R5: nonzero start raises busy
  a_r5_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrAddr && !busy && (wrData[CNT_W-1:0] != '0) |=> busy && !done);
  // R1: operand write alone leaves result alone
  a_r1_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !(wrEn && wrAddr) |=> $stable(result));
endmodule

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] result;
  logic       busy;
  logic       done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  shrot_unit #(.DATA_W(8), .CNT_W(4)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .result(result), .busy(busy), .done(done)
  );

  // {operand, control, expected}
  localparam logic [23:0] VEC [10] = '{
    {8'h96, 8'h11, 8'h2C},  // R3 shift left 1
    {8'h96, 8'h03, 8'h12},  // R3 shift right 3
    {8'h96, 8'h33, 8'hB4},  // R4 rotate left 3
    {8'h96, 8'h23, 8'hD2},  // R4 rotate right 3
    {8'h81, 8'h3F, 8'hC0},  // R4 rotate left 15 wraps
    {8'h81, 8'h0F, 8'h00},  // R3 shift right 15 clears
    {8'hA5, 8'h28, 8'hA5},  // R4 rotate right 8 returns operand
    {8'h5A, 8'h10, 8'h5A},  // R7 count 0
    {8'hFF, 8'h17, 8'h80},  // R3 shift left 7
    {8'h02, 8'hC1, 8'h01}   // R2 upper bits ignored, shift right 1
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  // caller has just issued the control write; now at negedge after it
  task automatic runOp(input int n, input logic [7:0] exp, input string tag);
    for (int k = 0; k < n; k++) begin
      chk(busy && !done, "R5 busy during steps", {busy, done}, 2'b10);
      @(negedge clk);
    end
    chk(done && !busy, "R6 done pulse", {busy, done}, 2'b01);
    chk(result == exp, tag, result, exp);
    @(negedge clk);
    chk(!done, "R6 done one cycle", done, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(result == 8'h00 && !busy && !done, "R9 reset state", {result, busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      wr(1'b0, VEC[i][23:16]);
      wr(1'b1, VEC[i][15:8]);
      runOp(int'(VEC[i][11:8]), VEC[i][7:0], "R2 R3 R4 table result");
    end

    // R1: operand write does not disturb result
    wr(1'b0, 8'h3C);
    chk(result == 8'h01 && !busy && !done, "R1 result held after operand write", result, 8'h01);

    // R10: second control write starts from stored operand
    wr(1'b1, 8'h12);
    runOp(2, 8'hF0, "R10 first op");
    wr(1'b1, 8'h01);
    runOp(1, 8'h1E, "R10 restart from operand");

    // R8: writes while busy are ignored
    wr(1'b0, 8'h81);
    wr(1'b1, 8'h35);           // rotate left 5 -> 0x30
    chk(busy, "R8 busy after start", busy, 1);
    wr(1'b0, 8'hFF);           // ignored
    wr(1'b1, 8'h00);           // ignored
    runOp(3, 8'h30, "R8 result unaffected by busy writes");
    wr(1'b1, 8'h00);           // count 0 reveals stored operand
    runOp(0, 8'h81, "R8 operand unaffected, R7 count 0");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule